// File: doc/BRIEF.md
# Zoned External Data-Memory Wait-State Controller

This block sits between a processor's data-memory access port and the external memory bus of a 14-bit data space. On each access it classifies the address into one of three external zones, the on-chip memory window, a reserved window or the control-register window. Accesses to on-chip, reserved and register addresses finish in the cycle they are issued. Accesses to an external zone are stretched by that zone's own programmable wait count. During the whole stretched access the block holds a zone select and an external read or write strobe, and it drives ready low until the final cycle.

A 16-bit wait control word holds one 3-bit count for each external zone. It also holds two more 3-bit compatibility fields that software can write and read back but that never alter timing. Reset loads every field with seven. The master holds its request until it sees ready high. If the request stays asserted after a ready cycle, a new access starts on the next cycle.

Top module: `dmem_wait_ctrl`

## Requirements
- R1: External zones are decoded as zone 0 = 0x0000–0x03FF, zone 1 = 0x0400–0x07FF and zone 2 = 0x0800–0x2FFF. Bit i of `sel_ext` is the only select high for an access to zone i.
- R2: An access to 0x3000–0x37FF raises only `sel_int`. Ready is high in the same cycle and no external strobe is driven.
- R3: An access to 0x3800–0x3BFF raises only `sel_rsv` and is ready in the same cycle with no external strobe. On a read (`acc_we`=0), `rd_zero` is high so that the returned data is forced to zero.
- R4: An access to 0x3C00–0x3FFF raises only `sel_reg` and is ready in the same cycle with no external strobe.
- R5: The wait control word holds zone 0 in bits [2:0], zone 1 in bits [5:3] and zone 2 in bits [8:6]. Bit 15 always reads 0. After reset `cfg_rdata` reads 0x7FFF. A write with `cfg_we`=1 takes effect at the clock edge.
- R6: For an external access with wait count N, counting the start cycle as cycle 0, ready is low in cycles 0 to N−1 and high in cycle N. With N=0, ready is high in the start cycle.
- R7: `ext_rd` (read) or `ext_wr` (write) is high from the start cycle through the ready cycle inclusive, and only for external-zone accesses. The two are never high together.
- R8: The compatibility fields in bits [11:9] and [14:12] are writable and read back, and they have no effect on the length of any access.
- R9: A control write in the start cycle of an access, or during its stall, does not change that access's length. The count in effect before the start edge is used, and the new value applies to accesses that start after the write edge.
- R10: Zone select and strobe direction are fixed in the start cycle and held for the rest of the access, even if `acc_addr` or `acc_we` change.
- R11: If `acc_req` stays high after a ready cycle, the next access starts in the following cycle.
- R12: With `acc_req` low and no access in flight, all selects, both strobes and `rd_zero` are low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Access request, held until ready |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 14 | Data-memory word address |
| cfg_we | input | 1 | Wait control word write enable |
| cfg_wdata | input | 16 | Wait control word write value |
| cfg_rdata | output | 16 | Wait control word read-back |
| sel_ext | output | 3 | One-hot external zone select |
| sel_int | output | 1 | On-chip memory window select |
| sel_rsv | output | 1 | Reserved window select |
| sel_reg | output | 1 | Register window select |
| ready | output | 1 | Access completes this cycle |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| rd_zero | output | 1 | Force read data to zero |

## Verification
The control-word write and the start of an external access can fall on the same clock edge. A write can also land in the middle of a stretched access. The bench provokes both cases with directed writes placed exactly on a start cycle and on a stall cycle, and with random writes mixed into a random access stream. Each case is judged by a bench model that takes the count in effect before the start edge for the access already in flight, and the new count for every access started after the write edge.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

    // Region classes produced by the address decoder
    typedef enum logic [1:0] {
        KIND_EXT = 2'd0,
        KIND_INT = 2'd1,
        KIND_RSV = 2'd2,
        KIND_REG = 2'd3
    } kind_e;

endpackage

// File: rtl/dmw_addr_decode.sv
module dmw_addr_decode
    import dmw_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NUM_ZONES = 3,
    parameter logic [NUM_ZONES*ADDR_W-1:0] ZONE_BASE = {14'h0800, 14'h0400, 14'h0000},
    parameter logic [ADDR_W-1:0] INT_BASE = 14'h3000,
    parameter logic [ADDR_W-1:0] RSV_BASE = 14'h3800,
    parameter logic [ADDR_W-1:0] REG_BASE = 14'h3C00
) (
    input  logic [ADDR_W-1:0]    addr,
    output kind_e                kind,
    output logic [NUM_ZONES-1:0] zone_hit
);

    // One window comparator per external zone; the last zone ends at the on-chip base
    for (genvar i = 0; i < NUM_ZONES; i++) begin : g_zone
        localparam logic [ADDR_W-1:0] LO = ZONE_BASE[i*ADDR_W +: ADDR_W];
        if (i == NUM_ZONES - 1) begin : g_last
            assign zone_hit[i] = (addr >= LO) && (addr < INT_BASE);
        end else begin : g_mid
            localparam logic [ADDR_W-1:0] HI = ZONE_BASE[(i+1)*ADDR_W +: ADDR_W];
            assign zone_hit[i] = (addr >= LO) && (addr < HI);
        end
    end

    always_comb begin
        if (|zone_hit) begin
            kind = KIND_EXT;
        end else if (addr >= INT_BASE && addr < RSV_BASE) begin
            kind = KIND_INT;
        end else if (addr >= REG_BASE) begin
            kind = KIND_REG;
        end else begin
            kind = KIND_RSV;
        end
    end

endmodule

// File: rtl/dmw_cfg_reg.sv
module dmw_cfg_reg #(
    parameter int WS_W      = 3,
    parameter int NUM_ZONES = 3,
    parameter int NUM_SPARE = 2,
    parameter int REG_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REG_W-1:0]          wr_data,
    output logic [REG_W-1:0]          rd_data,
    output logic [NUM_ZONES*WS_W-1:0] wait_vec
);

    localparam int FIELD_W = (NUM_ZONES + NUM_SPARE) * WS_W;
    localparam logic [REG_W-1:0] FIELD_MASK = {REG_W{1'b1}} >> (REG_W - FIELD_W);

    typedef struct packed {
        logic [REG_W-1:0] word;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.word = wr_data & FIELD_MASK;
        end
    end

    // Every field, zone or spare, comes out of reset at its largest count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.word <= FIELD_MASK;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_data  = cfg_q.word;
    assign wait_vec = cfg_q.word[NUM_ZONES*WS_W-1:0];

endmodule

// File: rtl/dmw_wait_seq.sv
module dmw_wait_seq
    import dmw_pkg::*;
#(
    parameter int WS_W      = 3,
    parameter int NUM_ZONES = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic                      we,
    input  kind_e                     kind,
    input  logic [NUM_ZONES-1:0]      zone_hit,
    input  logic [NUM_ZONES*WS_W-1:0] wait_vec,
    output logic                      busy,
    output logic                      ready,
    output logic [NUM_ZONES-1:0]      zone_sel,
    output logic                      strobe_rd,
    output logic                      strobe_wr
);

    typedef struct packed {
        logic                 busy;
        logic [WS_W-1:0]      cnt;
        logic [NUM_ZONES-1:0] zone;
        logic                 we;
    } seq_t;

    seq_t st_d, st_q;
    logic [WS_W-1:0] zone_wait;

    // Count of the zone hit by the current address (one-hot select, OR-reduced)
    always_comb begin
        zone_wait = '0;
        for (int i = 0; i < NUM_ZONES; i++) begin
            if (zone_hit[i]) begin
                zone_wait = zone_wait | wait_vec[i*WS_W +: WS_W];
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        ready     = 1'b1;
        zone_sel  = '0;
        strobe_rd = 1'b0;
        strobe_wr = 1'b0;
        if (st_q.busy) begin
            // Stretched access: everything comes from the state latched at start
            zone_sel  = st_q.zone;
            strobe_rd = !st_q.we;
            strobe_wr = st_q.we;
            ready     = (st_q.cnt == WS_W'(1));
            st_d.cnt  = st_q.cnt - WS_W'(1);
            if (st_q.cnt == WS_W'(1)) begin
                st_d.busy = 1'b0;
            end
        end else if (req && kind == KIND_EXT) begin
            zone_sel  = zone_hit;
            strobe_rd = !we;
            strobe_wr = we;
            ready     = (zone_wait == '0);
            if (zone_wait != '0) begin
                st_d.busy = 1'b1;
                st_d.cnt  = zone_wait;
                st_d.zone = zone_hit;
                st_d.we   = we;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

endmodule

// File: rtl/dmem_wait_ctrl.sv
module dmem_wait_ctrl
    import dmw_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int WS_W      = 3,
    parameter int NUM_ZONES = 3,
    parameter int NUM_SPARE = 2,
    parameter int REG_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_req,
    input  logic                 acc_we,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 cfg_we,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    output logic [NUM_ZONES-1:0] sel_ext,
    output logic                 sel_int,
    output logic                 sel_rsv,
    output logic                 sel_reg,
    output logic                 ready,
    output logic                 ext_rd,
    output logic                 ext_wr,
    output logic                 rd_zero
);

    kind_e                     kind;
    logic [NUM_ZONES-1:0]      zone_hit;
    logic [NUM_ZONES*WS_W-1:0] wait_vec;
    logic                      busy;
    logic                      fresh;

    dmw_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_ZONES (NUM_ZONES)
    ) u_decode (
        .addr     (acc_addr),
        .kind     (kind),
        .zone_hit (zone_hit)
    );

    dmw_cfg_reg #(
        .WS_W      (WS_W),
        .NUM_ZONES (NUM_ZONES),
        .NUM_SPARE (NUM_SPARE),
        .REG_W     (REG_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_data  (cfg_wdata),
        .rd_data  (cfg_rdata),
        .wait_vec (wait_vec)
    );

    dmw_wait_seq #(
        .WS_W      (WS_W),
        .NUM_ZONES (NUM_ZONES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (acc_req),
        .we        (acc_we),
        .kind      (kind),
        .zone_hit  (zone_hit),
        .wait_vec  (wait_vec),
        .busy      (busy),
        .ready     (ready),
        .zone_sel  (sel_ext),
        .strobe_rd (ext_rd),
        .strobe_wr (ext_wr)
    );

    // Non-external windows answer only to a request that is not inside a stretch
    assign fresh   = acc_req && !busy;
    assign sel_int = fresh && (kind == KIND_INT);
    assign sel_rsv = fresh && (kind == KIND_RSV);
    assign sel_reg = fresh && (kind == KIND_REG);
    assign rd_zero = sel_rsv && !acc_we;

endmodule

// File: rtl/dmw_checker.sv
module dmw_checker #(
    parameter int WS_W      = 3,
    parameter int NUM_ZONES = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_req,
    input logic                 acc_we,
    input logic [NUM_ZONES-1:0] sel_ext,
    input logic                 sel_int,
    input logic                 sel_rsv,
    input logic                 sel_reg,
    input logic                 ready,
    input logic                 ext_rd,
    input logic                 ext_wr,
    input logic                 rd_zero
);

    localparam int MAX_WAIT = (1 << WS_W) - 1;

    logic [WS_W:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (ready) begin
            low_run <= '0;
        end else begin
            low_run <= low_run + 1'b1;
        end
    end

    // R1
    one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ext, sel_int, sel_rsv, sel_reg}));

    // R7
    strobe_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd || ext_wr) |-> (sel_ext != '0));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));

    // R2
    int_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_int |-> (ready && !ext_rd && !ext_wr));

    // R4
    reg_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_reg |-> (ready && !ext_rd && !ext_wr));

    // R3
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rsv && !acc_we) |-> (rd_zero && ready));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && (ext_rd || ext_wr)) |=> ($stable(sel_ext) && $stable({ext_rd, ext_wr})));

    // R6
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (low_run < (WS_W+1)'(MAX_WAIT)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ready) && !acc_req) |-> (ready && sel_ext == '0 && !ext_rd && !ext_wr && !rd_zero));

endmodule

bind dmem_wait_ctrl dmw_checker #(
    .WS_W      (WS_W),
    .NUM_ZONES (NUM_ZONES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_req (acc_req),
    .acc_we  (acc_we),
    .sel_ext (sel_ext),
    .sel_int (sel_int),
    .sel_rsv (sel_rsv),
    .sel_reg (sel_reg),
    .ready   (ready),
    .ext_rd  (ext_rd),
    .ext_wr  (ext_wr),
    .rd_zero (rd_zero)
);

// File: tb/dmem_wait_ctrl_bench.sv
`timescale 1ns/1ps
module dmem_wait_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic [13:0] acc_addr = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [2:0]  sel_ext;
    logic        sel_int, sel_rsv, sel_reg, ready, ext_rd, ext_wr, rd_zero;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] model = 16'h7FFF;

    always #2.5 clk = ~clk;

    dmem_wait_ctrl u_dmem_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
        .acc_addr(acc_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sel_ext(sel_ext), .sel_int(sel_int),
        .sel_rsv(sel_rsv), .sel_reg(sel_reg), .ready(ready),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .rd_zero(rd_zero)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // 0,1,2 = external zone; -1 = not external
    function automatic int zone_of(logic [13:0] a);
        if (a < 14'h0400) return 0;
        if (a < 14'h0800) return 1;
        if (a < 14'h3000) return 2;
        return -1;
    endfunction

    // 1 = on-chip, 2 = reserved, 3 = registers
    function automatic int win_of(logic [13:0] a);
        if (a < 14'h3000) return 0;
        if (a < 14'h3800) return 1;
        if (a < 14'h3C00) return 2;
        return 3;
    endfunction

    function automatic int wait_of(logic [15:0] m, logic [13:0] a);
        int z = zone_of(a);
        if (z < 0) return 0;
        return int'((m >> (3*z)) & 16'h7);
    endfunction

    task automatic go_idle();
        acc_req = 1'b0;
        @(negedge clk);
        #1;
        chk("R12 ready idle", ready, 1);
        chk("R12 selects idle", {sel_ext, sel_int, sel_rsv, sel_reg}, 0);
        chk("R12 strobes idle", {ext_rd, ext_wr, rd_zero}, 0);
    endtask

    // Called at a falling edge; returns at the falling edge after the ready cycle.
    task automatic do_access(logic [13:0] a, logic w, bit wr_start, bit wr_mid,
                             logic [15:0] wval, bit scramble);
        int  n    = wait_of(model, a);
        int  z    = zone_of(a);
        int  r    = win_of(a);
        bit  pend = 0;
        bit  mid_done = 0;
        acc_req  = 1'b1;
        acc_addr = a;
        acc_we   = w;
        if (wr_start) begin
            cfg_we = 1'b1; cfg_wdata = wval; pend = 1;
        end
        for (int k = 0; ; k++) begin
            #1;
            chk("R6 ready timing", ready, (k == n) ? 1 : 0);
            if (z >= 0) begin
                chk("R1 zone select", sel_ext, 3'b1 << z);
                chk("R7 strobes held", {ext_rd, ext_wr}, {!w, w});
            end else if (k == 0) begin
                chk("R2 int select", sel_int, r == 1);
                chk("R3 rsv select", sel_rsv, r == 2);
                chk("R4 reg select", sel_reg, r == 3);
                chk("R3 read zero", rd_zero, (r == 2) && !w);
                chk("R2 R4 no strobe", {ext_rd, ext_wr, sel_ext}, 0);
            end
            if (ready === 1'b1 || k > 9) break;
            @(negedge clk);
            if (pend) begin
                cfg_we = 1'b0; model = wval & 16'h7FFF; pend = 0;
            end
            if (wr_mid && !mid_done) begin
                cfg_we = 1'b1; cfg_wdata = wval; pend = 1; mid_done = 1;
            end
            if (scramble) begin
                acc_addr = 14'h3000 | 14'($urandom_range(0, 16'h07FF));
                acc_we   = !w;
            end
        end
        @(negedge clk);
        if (pend) begin
            cfg_we = 1'b0; model = wval & 16'h7FFF;
        end
    endtask

    task automatic write_cfg(logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        model = v & 16'h7FFF;
        #1;
        chk("R5 R8 readback", cfg_rdata, v & 16'h7FFF);
        @(negedge clk);
    endtask

    logic [13:0] edges [12] = '{14'h0000, 14'h03FF, 14'h0400, 14'h07FF, 14'h0800, 14'h2FFF,
                                14'h3000, 14'h37FF, 14'h3800, 14'h3BFF, 14'h3C00, 14'h3FFF};

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk("R5 reset word", cfg_rdata, 16'h7FFF);
        chk("R12 reset ready", ready, 1);
        chk("R12 reset selects", {sel_ext, sel_int, sel_rsv, sel_reg, ext_rd, ext_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R6: every window boundary at reset counts, read and write
        foreach (edges[i]) begin
            do_access(edges[i], 1'b0, 0, 0, 16'h0, 0);
            go_idle();
            do_access(edges[i], 1'b1, 0, 0, 16'h0, 0);
            go_idle();
        end

        // R5: distinct counts per zone, bit 15 dropped
        write_cfg(16'h8000 | (3'd2 << 12) | (3'd6 << 9) | (3'd5 << 6) | (3'd3 << 3) | 3'd0);
        for (int z = 0; z < 3; z++) begin
            do_access(14'(z * 14'h0400 + 14'h0010), 1'b0, 0, 0, 16'h0, 0);
            go_idle();
        end

        // R8: spare fields alone change, zone timing must not
        write_cfg(16'h0000 | (3'd5 << 6) | (3'd3 << 3) | 3'd0);
        do_access(14'h0900, 1'b1, 0, 0, 16'h0, 0);
        go_idle();
        write_cfg(16'h7E00 | (3'd5 << 6) | (3'd3 << 3) | 3'd0);
        do_access(14'h0900, 1'b1, 0, 0, 16'h0, 0);
        go_idle();

        // R9: write on the start edge, then on a stall edge
        do_access(14'h0410, 1'b0, 1, 0, 16'h0038, 0);
        do_access(14'h0410, 1'b0, 0, 0, 16'h0, 0);
        go_idle();
        do_access(14'h0800, 1'b1, 0, 1, 16'h0040, 0);
        do_access(14'h0800, 1'b1, 0, 0, 16'h0, 0);
        go_idle();

        // R10: address and direction change mid-stretch
        write_cfg(16'h7FFF);
        do_access(14'h0123, 1'b0, 0, 0, 16'h0, 1);
        go_idle();

        // R11: back-to-back without dropping the request
        do_access(14'h0500, 1'b1, 0, 0, 16'h0, 0);
        do_access(14'h3100, 1'b0, 0, 0, 16'h0, 0);
        do_access(14'h2000, 1'b0, 0, 0, 16'h0, 0);
        go_idle();

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [13:0] a = 14'($urandom);
            logic        w = 1'($urandom);
            bit ws = ($urandom_range(0, 5) == 0);
            bit wm = !ws && ($urandom_range(0, 7) == 0);
            bit sc = ($urandom_range(0, 4) == 0);
            do_access(a, w, ws, wm, 16'($urandom), sc);
            if ($urandom_range(0, 3) == 0) go_idle();
        end
        go_idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule